// File: doc/BRIEF.md
# Packet Completion Interrupt Coalescer

This block tracks the completed output traffic of a single ring and decides when the host should be interrupted. Every packet-sent strobe grows a running count. The count grows by one per packet, or by the packet's byte length when byte mode is programmed. Software acknowledges work by writing an amount to the count register, and that amount is taken off the running total. Software does not load the register directly. To drain the count completely, software reads the count and writes the same value back.

While work is pending, a coarse age timer measures how long it has been waiting. The timer advances once per prescaler period and only while the count is nonzero. An interrupt level is raised when the count passes its threshold or when the age passes its threshold. Software can also ask for the interrupt message to be sent again. The request is honoured only if a threshold condition still holds at the moment of the request.

Top module: `pkt_cmpl_coalescer`

## Requirements
- R1: With byte mode off, each cycle with `pkt_sent` high adds exactly one to `count_o`. The new value is visible after the next rising clock edge.
- R2: Byte mode is bit 63 of a levels write (`wr_sel`=0). With byte mode on, each strobe adds `pkt_len` to `count_o`.
- R3: A count write (`wr_sel`=1) subtracts `wr_data[CNT_W-1:0]` from `count_o`. If the amount exceeds the count, the result is zero.
- R4: A strobe and a count write in the same cycle both take effect. The result is count + add - subtract, saturated at zero.
- R5: While `count_o` is nonzero, `age_o` increments once every PRESCALE (default 2048) cycles. The first increment comes PRESCALE cycles after the count leaves zero, because the prescaler restarts from zero each time the count goes from zero to nonzero.
- R6: On the clock edge where `count_o` becomes zero, `age_o` also becomes zero and `irq_o` drops.
- R7: `irq_o` is high whenever `count_o` is strictly greater than the count threshold. The count threshold is `wr_data[CNT_W-1:0]` of a levels write.
- R8: `irq_o` is high whenever `age_o` is strictly greater than the time threshold. The time threshold is `wr_data[32+TMR_W-1:32]` of a levels write.
- R9: A resend write (`wr_sel`=2 with `wr_data[0]`=1) produces a one-cycle `resend_o` pulse in the following cycle if `irq_o` is high in the cycle of the write. If `irq_o` is low, no pulse is produced.
- R10: After reset, `count_o`, `age_o`, `irq_o` and `resend_o` are all zero, and both thresholds are zero.
- R11: The count saturates at its all-ones value instead of wrapping when additions would overflow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_sent | input | 1 | One packet completed this cycle |
| pkt_len | input | LEN_W | Byte length of the completed packet |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 = levels, 1 = count subtract, 2 = resend, 3 = no effect |
| wr_data | input | DATA_W | Write data |
| count_o | output | CNT_W | Current pending count |
| age_o | output | TMR_W | Age timer |
| irq_o | output | 1 | Interrupt level |
| resend_o | output | 1 | One-cycle resend request for the message generator |

## Verification
The count is driven in three ways, and each pattern isolates a different path:
- Packet-mode strobes separate the unit increment from the length path.
- Byte-mode strobes of unequal length expose any mix-up between the two add sources.
- A combined strobe and subtract in one cycle shows whether both updates are applied or one shadows the other.

The thresholds are probed exactly at equality and one step above, which separates a strict comparison from an inclusive one. The age timer is sampled one cycle before and at the expected tick, both after a first arrival and after a drain-and-refill in mid-period, which shows whether the prescaler restarts. Over-subtraction and a long run of maximum-length packets check the two saturation limits. Resend writes are issued with the interrupt condition both true and false.

// File: rtl/cmpl_coal_pkg.sv
package cmpl_coal_pkg;
  typedef enum logic [1:0] {
    SEL_LEVELS = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_RESEND = 2'd2,
    SEL_NONE   = 2'd3
  } wsel_e;

  localparam int TTHR_LSB = 32;
endpackage

// File: rtl/cmpl_count_acc.sv
module cmpl_count_acc #(
  parameter int CNT_W = 22,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_sent,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             byte_mode,
  input  logic             sub_en,
  input  logic [CNT_W-1:0] sub_amt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero_next
);
  localparam int BASE_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;
  localparam int SUM_W  = BASE_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Saturating net update: cur + add - sub, clamped to [0, CNT_MAX]
  function automatic logic [CNT_W-1:0] net_count(
    input logic [CNT_W-1:0] cur,
    input logic [SUM_W-1:0] add,
    input logic [CNT_W-1:0] sub
  );
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] diff;
    sum = SUM_W'(cur) + add;
    if (SUM_W'(sub) >= sum) begin
      return '0;
    end
    diff = sum - SUM_W'(sub);
    if (diff > SUM_W'(CNT_MAX)) begin
      return CNT_MAX;
    end
    return diff[CNT_W-1:0];
  endfunction

  logic [SUM_W-1:0] add_amt;
  logic [CNT_W-1:0] sub_eff;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!pkt_sent) add_amt = '0;
    else if (byte_mode) add_amt = SUM_W'(pkt_len);
    else add_amt = SUM_W'(1);
    sub_eff = sub_en ? sub_amt : '0;
    cnt_d   = net_count(cnt_q, add_amt, sub_eff);
  end

  assign cnt_zero_next = (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  // R1: one per strobe in packet mode
  p_pkt_add_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && !byte_mode && !sub_en && cnt_q != CNT_MAX)
      |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R3: over-subtraction lands on zero
  p_sub_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en && !pkt_sent && sub_amt >= cnt_q) |=> cnt_q == '0);

  // R11: no wrap on saturated count
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !sub_en) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/cmpl_age_timer.sv
module cmpl_age_timer #(
  parameter int TMR_W    = 22,
  parameter int PRESCALE = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_nonzero,
  input  logic             clear_now,
  output logic [TMR_W-1:0] tmr_q,
  output logic             tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [PRE_W-1:0] pre_q;

  assign tick = cnt_nonzero && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_now) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else if (cnt_nonzero) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
      if (tick && tmr_q != TMR_MAX) tmr_q <= tmr_q + TMR_W'(1);
    end
  end

  // R5: timer moves only on a prescaler tick
  p_age_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear_now) |=> $stable(tmr_q));

  // R5: a tick advances the timer by exactly one
  p_age_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear_now && tmr_q != TMR_MAX) |=> tmr_q == $past(tmr_q) + TMR_W'(1));
endmodule

// File: rtl/cmpl_irq_eval.sv
module cmpl_irq_eval #(
  parameter int CNT_W = 22,
  parameter int TMR_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [TMR_W-1:0] tmr,
  input  logic [CNT_W-1:0] cnt_thr,
  input  logic [TMR_W-1:0] tmr_thr,
  input  logic             resend_req,
  output logic             irq,
  output logic             resend_q
);
  logic cnt_over;
  logic age_over;

  assign cnt_over = (cnt > cnt_thr);
  assign age_over = (tmr > tmr_thr);
  assign irq      = cnt_over || age_over;

  always_ff @(posedge clk) begin
    if (!rst_n) resend_q <= 1'b0;
    else resend_q <= resend_req && irq;
  end

  // R9: a resend pulse always has a live condition and a request behind it
  p_resend_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resend_q |-> ($past(resend_req) && $past(irq)));
endmodule

// File: rtl/pkt_cmpl_coalescer.sv
module pkt_cmpl_coalescer #(
  parameter int CNT_W    = 22,
  parameter int TMR_W    = 22,
  parameter int LEN_W    = 16,
  parameter int DATA_W   = 64,
  parameter int PRESCALE = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_sent,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic [TMR_W-1:0]  age_o,
  output logic              irq_o,
  output logic              resend_o
);
  import cmpl_coal_pkg::*;

  localparam int BMODE_BIT = DATA_W - 1;

  wsel_e            sel;
  logic             wr_levels;
  logic             wr_count;
  logic             wr_resend;
  logic [CNT_W-1:0] cthr_q;
  logic [TMR_W-1:0] tthr_q;
  logic             bmode_q;
  logic             cnt_zero_next;
  logic             age_tick;
  logic             unused_wr_bits;

  assign sel       = wsel_e'(wr_sel);
  assign wr_levels = wr_en && (sel == SEL_LEVELS);
  assign wr_count  = wr_en && (sel == SEL_COUNT);
  assign wr_resend = wr_en && (sel == SEL_RESEND) && wr_data[0];
  assign unused_wr_bits = ^{wr_data, age_tick};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cthr_q  <= '0;
      tthr_q  <= '0;
      bmode_q <= 1'b0;
    end else if (wr_levels) begin
      cthr_q  <= wr_data[CNT_W-1:0];
      tthr_q  <= wr_data[TTHR_LSB +: TMR_W];
      bmode_q <= wr_data[BMODE_BIT];
    end
  end

  cmpl_count_acc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_count (
    .clk           (clk),
    .rst_n         (rst_n),
    .pkt_sent      (pkt_sent),
    .pkt_len       (pkt_len),
    .byte_mode     (bmode_q),
    .sub_en        (wr_count),
    .sub_amt       (wr_data[CNT_W-1:0]),
    .cnt_q         (count_o),
    .cnt_zero_next (cnt_zero_next)
  );

  cmpl_age_timer #(.TMR_W(TMR_W), .PRESCALE(PRESCALE)) u_age (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_nonzero (count_o != '0),
    .clear_now   (cnt_zero_next),
    .tmr_q       (age_o),
    .tick        (age_tick)
  );

  cmpl_irq_eval #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (count_o),
    .tmr        (age_o),
    .cnt_thr    (cthr_q),
    .tmr_thr    (tthr_q),
    .resend_req (wr_resend),
    .irq        (irq_o),
    .resend_q   (resend_o)
  );

  // R6: an empty ring carries no age and no interrupt
  p_empty_is_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0) |-> (age_o == '0 && !irq_o));
endmodule

// File: tb/test_pkt_cmpl_coalescer.sv
`timescale 1ns/1ps
module test_pkt_cmpl_coalescer;
  localparam int CNT_W = 22, TMR_W = 22, LEN_W = 16, DATA_W = 64, PRESCALE = 2048;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;
  localparam longint TMAX = (64'd1 << TMR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_sent = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] count_o;
  logic [TMR_W-1:0] age_o;
  logic irq_o, resend_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pkt_cmpl_coalescer #(.CNT_W(CNT_W), .TMR_W(TMR_W), .LEN_W(LEN_W),
    .DATA_W(DATA_W), .PRESCALE(PRESCALE)) i_pkt_cmpl_coalescer (
    .clk(clk), .rst_n(rst_n), .pkt_sent(pkt_sent), .pkt_len(pkt_len),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_o(count_o), .age_o(age_o), .irq_o(irq_o), .resend_o(resend_o));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_levels(input longint cthr, input longint tthr, input bit bmode);
    wr_data = '0;
    wr_data[CNT_W-1:0] = cthr[CNT_W-1:0];
    wr_data[32 +: TMR_W] = tthr[TMR_W-1:0];
    wr_data[63] = bmode;
    wr_sel = 2'd0; wr_en = 1'b1;
    step();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic subtract(input longint amt);
    wr_data = '0; wr_data[CNT_W-1:0] = amt[CNT_W-1:0];
    wr_sel = 2'd1; wr_en = 1'b1;
    step();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic send(input int len);
    pkt_sent = 1'b1; pkt_len = LEN_W'(len);
    step();
    pkt_sent = 1'b0; pkt_len = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    check("R10", "count", count_o, 0);
    check("R10", "age", age_o, 0);
    check("R10", "irq", irq_o, 0);
    check("R10", "resend", resend_o, 0);
  endtask

  task automatic t_packet_mode();
    set_levels(3, TMAX, 0);
    for (int i = 0; i < 3; i++) send(100);
    check("R1", "count after 3 packets", count_o, 3);
    check("R7", "irq at count equal to threshold", irq_o, 0);
    send(100);
    check("R1", "count after 4 packets", count_o, 4);
    check("R7", "irq above threshold", irq_o, 1);
    subtract(4);
    check("R3", "count after exact subtract", count_o, 0);
    check("R6", "irq after drain", irq_o, 0);
    send(7); send(7);
    subtract(5);
    check("R3", "count after over-subtract", count_o, 0);
  endtask

  task automatic t_byte_mode();
    set_levels(1000, TMAX, 1);
    send(600);
    check("R2", "byte count 600", count_o, 600);
    check("R7", "irq below threshold", irq_o, 0);
    send(500);
    check("R2", "byte count 1100", count_o, 1100);
    check("R7", "irq above byte threshold", irq_o, 1);
    pkt_sent = 1'b1; pkt_len = 16'd40;
    wr_data = '0; wr_data[CNT_W-1:0] = 22'd140; wr_sel = 2'd1; wr_en = 1'b1;
    step();
    pkt_sent = 1'b0; pkt_len = '0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    check("R4", "add and subtract together", count_o, 1000);
    check("R7", "irq at equality", irq_o, 0);
    subtract(1000);
    check("R3", "read-and-write-back drain", count_o, 0);
  endtask

  task automatic t_overflow();
    set_levels(CMAX, TMAX, 1);
    for (int i = 0; i < 65; i++) send(65535);
    check("R11", "count saturates", count_o, CMAX);
    subtract(CMAX);
    check("R3", "drain after saturation", count_o, 0);
  endtask

  task automatic t_age_and_resend();
    set_levels(CMAX, 1, 0);
    wr_sel = 2'd2; wr_data = 64'd1; wr_en = 1'b1; step();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    check("R9", "no resend without condition", resend_o, 0);
    send(1);
    idle(PRESCALE - 1);
    check("R5", "age one cycle before first tick", age_o, 0);
    step();
    check("R5", "age at first tick", age_o, 1);
    check("R8", "irq at age equal to threshold", irq_o, 0);
    idle(PRESCALE);
    check("R5", "age at second tick", age_o, 2);
    check("R8", "irq above age threshold", irq_o, 1);
    wr_sel = 2'd2; wr_data = 64'd1; wr_en = 1'b1; step();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    check("R9", "resend pulse", resend_o, 1);
    step();
    check("R9", "resend is one cycle", resend_o, 0);
    subtract(1);
    check("R6", "age cleared with count", age_o, 0);
    check("R6", "irq cleared with count", irq_o, 0);
    wr_sel = 2'd2; wr_data = 64'd1; wr_en = 1'b1; step();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    check("R9", "no resend after drain", resend_o, 0);
    // prescaler restart after a mid-period drain
    send(1);
    idle(1000);
    subtract(1);
    send(1);
    idle(PRESCALE - 1);
    check("R5", "restarted prescaler, before tick", age_o, 0);
    step();
    check("R5", "restarted prescaler, at tick", age_o, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_packet_mode();
    t_byte_mode();
    t_overflow();
    t_age_and_resend();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule